// File: doc/BRIEF.md
# SD Four-Line Read Data Receiver

This block takes in read data blocks from a memory card whose data bus runs four lines wide. It samples the four data lines once per bus period. The bus period comes from a programmable divider of the system clock. While it waits for a block, it watches for a sample in which every line is low. From that point it gathers nibbles into bytes and passes each byte out as a one-cycle strobe. At the same time, a separate 16-bit CRC is run on each line. After the data and CRC nibbles, it expects a closing sample with every line high.

A read operation is started with a pulse on `start`. That pulse captures the number of blocks wanted and whether CRC checking is on. Blocks are then received back to back until the count is reached. The operation ends early on the first fault: a bad closing sample, a CRC mismatch while checking is on, or a start bit that does not come within the programmed number of bus periods. The good-block count then tells the caller which block failed. With checking off, the CRC nibbles are still clocked in but never judged.

Top module: `sd_nib_rx`

## Requirements
- R1: The data lines are sampled once every `divSel` system clocks, with values below 2 treated as 2. The first sample comes `divSel` clocks after the clock edge that accepts `start`. A block begins at the first sample, taken while waiting, in which all four lines read 0.
- R2: Each block carries 512 data bytes, sent as 1024 nibbles. In every pair of nibbles the first is the high nibble, and line 3 is the most significant bit of each nibble. `outValid` pulses for one clock with the byte in `outByte` once per byte, which gives exactly 512 pulses per block.
- R3: Each line has its own CRC over its 1024 data bits. The generator is x^16+x^12+x^5+1, starting from zero. The 16 check bits for each line follow that line's data, most significant bit first.
- R4: With checking enabled, a CRC mismatch on any line ends the operation at the closing sample of that block. `errCode` becomes 1, and `blkCount` keeps the number of blocks that were good before it.
- R5: With checking disabled, blocks whose check bits are wrong are still counted as good, and the operation runs to the requested count.
- R6: The sample after the last check nibble must read 4'hF. Any other value ends the operation with `errCode` 2, whether or not checking is enabled.
- R7: Each good block raises `blkDone` for one clock and adds one to `blkCount`. The operation ends, with `busy` low, once `blkCount` equals the captured `blkTotal`. A `start` with `blkTotal` = 0 is ignored.
- R8: If `toLimit` consecutive samples pass while waiting for a start bit, the operation ends with `errCode` 3. With `toLimit` = 0 there is no time limit.
- R9: After reset, `busy`, `outValid`, `blkDone`, `blkCount` and `errCode` are all zero. An accepted `start` clears `blkCount` and `errCode`. `errFlag` is high exactly while `errCode` is non-zero, and while idle neither value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a read operation when idle |
| crcEn | input | 1 | CRC checking for this operation |
| blkTotal | input | 8 | Number of blocks to receive |
| divSel | input | 10 | System clocks per bus sample |
| toLimit | input | 16 | Samples allowed before a start bit, 0 = unlimited |
| dat | input | 4 | Card data lines, bit 3 = line 3 |
| outByte | output | 8 | Received data byte |
| outValid | output | 1 | One-cycle strobe for `outByte` |
| blkDone | output | 1 | One-cycle strobe per good block |
| blkCount | output | 8 | Good blocks in the current operation |
| busy | output | 1 | Operation in progress |
| errFlag | output | 1 | Operation ended on a fault |
| errCode | output | 2 | 0 none, 1 CRC, 2 closing sample, 3 timeout |

## Verification
Every result is registered on the system clock edge that takes the deciding sample. A byte therefore appears one clock after the edge that samples its low nibble. `blkDone`, the count update, the error code and the fall of `busy` all follow one clock after the edge that samples the closing nibble or the last sample allowed by the timeout. The bench changes the data lines on falling edges, exactly one bus period apart, starting at the falling edge after `start` is taken, so each value sits centred under its sampling edge. Results are read on falling edges: several bus periods after the last nibble, or, for the timeout boundary, at the falling edges just after sample 19 and sample 20.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;
  localparam int LANES = 4;
  localparam int CRC_BITS = 16;
  localparam logic [CRC_BITS-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_CRC     = 2'd1,
    ERR_FRAME   = 2'd2,
    ERR_TIMEOUT = 2'd3
  } err_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_DATA,
    S_END
  } state_e;

  typedef struct packed {
    logic blkClr;
    logic nibEn;
  } strobe_t;
endpackage

// File: rtl/sdrx_tick.sv
module sdrx_tick #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divSel,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] divEff;

  assign divEff = (divSel < DIV_W'(2)) ? DIV_W'(2) : divSel;
  assign tick   = run && (cnt == divEff - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/sdrx_crc_lane.sv
module sdrx_crc_lane
  import sdrx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                clr,
  input  logic                en,
  input  logic                bitIn,
  output logic [CRC_BITS-1:0] rem
);
  logic fb;
  assign fb = bitIn ^ rem[CRC_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    rem <= '0;
    else if (clr) rem <= '0;
    else if (en)  rem <= {rem[CRC_BITS-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end
endmodule

// File: rtl/sdrx_dp.sv
module sdrx_dp
  import sdrx_pkg::*;
#(
  parameter int BLK_BYTES = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [LANES-1:0] dat,
  output logic [7:0]       outByte,
  output logic             outValid,
  output logic             nibLast,
  output logic             crcZero
);
  localparam int DATA_NIBS = BLK_BYTES * 2;
  localparam int ALL_NIBS  = DATA_NIBS + CRC_BITS;
  localparam int NIB_W     = $clog2(ALL_NIBS + 1);

  logic [NIB_W-1:0]    nibIdx;
  logic [LANES-1:0]    hiNib;
  logic [LANES-1:0]    laneZero;
  logic                inData;

  assign inData  = nibIdx < NIB_W'(DATA_NIBS);
  assign nibLast = nibIdx == NIB_W'(ALL_NIBS - 1);
  assign crcZero = &laneZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nibIdx   <= '0;
      hiNib    <= '0;
      outByte  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= 1'b0;
      if (stb.blkClr) begin
        nibIdx <= '0;
      end else if (stb.nibEn) begin
        nibIdx <= nibIdx + NIB_W'(1);
        if (inData) begin
          if (!nibIdx[0]) begin
            hiNib <= dat;
          end else begin
            outByte  <= {hiNib, dat};
            outValid <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CRC_BITS-1:0] rem;
    sdrx_crc_lane u_crc (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (stb.blkClr),
      .en    (stb.nibEn),
      .bitIn (dat[g]),
      .rem   (rem)
    );
    assign laneZero[g] = (rem == '0);
  end
endmodule

// File: rtl/sdrx_ctrl.sv
module sdrx_ctrl
  import sdrx_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             crcEn,
  input  logic [CNT_W-1:0] blkTotal,
  input  logic [TO_W-1:0]  toLimit,
  input  logic             tick,
  input  logic [LANES-1:0] dat,
  input  logic             nibLast,
  input  logic             crcZero,
  output strobe_t          stb,
  output logic             busy,
  output logic             blkDone,
  output logic [CNT_W-1:0] blkCount,
  output err_e             errCode
);
  state_e           state;
  logic [CNT_W-1:0] totReg;
  logic             crcEnReg;
  logic [TO_W-1:0]  toCnt;
  logic [CNT_W-1:0] nextCnt;

  assign busy       = state != S_IDLE;
  assign nextCnt    = blkCount + CNT_W'(1);
  assign stb.blkClr = (state == S_WAIT) && tick && (dat == '0);
  assign stb.nibEn  = (state == S_DATA) && tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      totReg   <= '0;
      crcEnReg <= 1'b0;
      toCnt    <= '0;
      blkCount <= '0;
      errCode  <= ERR_NONE;
      blkDone  <= 1'b0;
    end else begin
      blkDone <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start && (blkTotal != '0)) begin
            state    <= S_WAIT;
            totReg   <= blkTotal;
            crcEnReg <= crcEn;
            toCnt    <= '0;
            blkCount <= '0;
            errCode  <= ERR_NONE;
          end
        end
        S_WAIT: begin
          if (tick) begin
            if (dat == '0) begin
              state <= S_DATA;
            end else if ((toLimit != '0) && (toCnt == toLimit - TO_W'(1))) begin
              state   <= S_IDLE;
              errCode <= ERR_TIMEOUT;
            end else begin
              toCnt <= toCnt + TO_W'(1);
            end
          end
        end
        S_DATA: begin
          if (tick && nibLast) state <= S_END;
        end
        S_END: begin
          if (tick) begin
            if (dat != '1) begin
              errCode <= ERR_FRAME;
              state   <= S_IDLE;
            end else if (crcEnReg && !crcZero) begin
              errCode <= ERR_CRC;
              state   <= S_IDLE;
            end else begin
              blkCount <= nextCnt;
              blkDone  <= 1'b1;
              toCnt    <= '0;
              state    <= (nextCnt == totReg) ? S_IDLE : S_WAIT;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_nib_rx.sv
module sd_nib_rx
  import sdrx_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int CNT_W     = 8,
  parameter int DIV_W     = 10,
  parameter int TO_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             crcEn,
  input  logic [CNT_W-1:0] blkTotal,
  input  logic [DIV_W-1:0] divSel,
  input  logic [TO_W-1:0]  toLimit,
  input  logic [3:0]       dat,
  output logic [7:0]       outByte,
  output logic             outValid,
  output logic             blkDone,
  output logic [CNT_W-1:0] blkCount,
  output logic             busy,
  output logic             errFlag,
  output logic [1:0]       errCode
);
  strobe_t stb;
  logic    tick;
  logic    nibLast;
  logic    crcZero;
  err_e    errSt;

  assign errCode = errSt;
  assign errFlag = errSt != ERR_NONE;

  sdrx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rstN   (rstN),
    .run    (busy),
    .divSel (divSel),
    .tick   (tick)
  );

  sdrx_ctrl #(.CNT_W(CNT_W), .TO_W(TO_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .crcEn    (crcEn),
    .blkTotal (blkTotal),
    .toLimit  (toLimit),
    .tick     (tick),
    .dat      (dat),
    .nibLast  (nibLast),
    .crcZero  (crcZero),
    .stb      (stb),
    .busy     (busy),
    .blkDone  (blkDone),
    .blkCount (blkCount),
    .errCode  (errSt)
  );

  sdrx_dp #(.BLK_BYTES(BLK_BYTES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dat      (dat),
    .outByte  (outByte),
    .outValid (outValid),
    .nibLast  (nibLast),
    .crcZero  (crcZero)
  );
endmodule

// File: rtl/sdrx_chk.sv
module sdrx_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             outValid,
  input logic             blkDone,
  input logic             errFlag,
  input logic [CNT_W-1:0] blkCount,
  input logic [1:0]       errCode
);
  // R2: bytes only while an operation runs, never on adjacent clocks
  a_r2_valid_busy: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);
  a_r2_valid_gap: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  // R7: a finished block is always counted and is never a faulty one
  a_r7_done_counted: assert property (@(posedge clk) disable iff (!rstN)
    blkDone |-> (blkCount != '0));
  a_r7_done_noerr: assert property (@(posedge clk) disable iff (!rstN)
    blkDone |-> !errFlag);
  // R4: a reported fault means the operation has ended
  a_r4_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !busy);
  // R9: idle results hold until the next start
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(blkCount));
  a_r9_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(errCode));
endmodule

bind sd_nib_rx sdrx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .outValid (outValid),
  .blkDone  (blkDone),
  .errFlag  (errFlag),
  .blkCount (blkCount),
  .errCode  (errCode)
);

// File: tb/sim_sd_nib_rx.sv
module sim_sd_nib_rx;
  localparam int BYTES = 512;

  typedef struct packed {
    logic       crcOn;
    logic [3:0] nBlk;
    logic [3:0] dv;
    logic [3:0] badBlk;
    logic [1:0] badKind;   // 0 none, 1 corrupt check bits, 2 bad closing nibble
    logic [3:0] expCnt;
    logic [1:0] expErr;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 4'd1, 4'd2, 4'd15, 2'd0, 4'd1, 2'd0},
    '{1'b1, 4'd3, 4'd3, 4'd15, 2'd0, 4'd3, 2'd0},
    '{1'b1, 4'd3, 4'd2, 4'd1,  2'd1, 4'd1, 2'd1},
    '{1'b0, 4'd2, 4'd2, 4'd0,  2'd1, 4'd2, 2'd0},
    '{1'b1, 4'd2, 4'd4, 4'd1,  2'd2, 4'd1, 2'd2},
    '{1'b0, 4'd1, 4'd2, 4'd0,  2'd2, 4'd0, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        crcEn = 1'b0;
  logic [7:0]  blkTotal = '0;
  logic [9:0]  divSel = 10'd2;
  logic [15:0] toLimit = 16'd50;
  logic [3:0]  dat = 4'hF;
  logic [7:0]  outByte;
  logic        outValid;
  logic        blkDone;
  logic [7:0]  blkCount;
  logic        busy;
  logic        errFlag;
  logic [1:0]  errCode;

  int nChecks = 0;
  int nFails  = 0;
  int curDiv  = 2;
  int monTotal = 0;
  int monBase  = 0;
  int monBad   = 0;
  int doneTotal = 0;

  always #10 clk = ~clk;

  sd_nib_rx u0 (
    .clk(clk), .rstN(rstN), .start(start), .crcEn(crcEn), .blkTotal(blkTotal),
    .divSel(divSel), .toLimit(toLimit), .dat(dat), .outByte(outByte),
    .outValid(outValid), .blkDone(blkDone), .blkCount(blkCount), .busy(busy),
    .errFlag(errFlag), .errCode(errCode)
  );

  function automatic logic [7:0] pat(int b, int i);
    return 8'((b * 29 + i * 7 + (i >> 4)) ^ 8'h5A);
  endfunction

  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (outByte != pat((monTotal - monBase) / BYTES, (monTotal - monBase) % BYTES))
        monBad = monBad + 1;
      monTotal = monTotal + 1;
    end
    if (rstN && blkDone) doneTotal = doneTotal + 1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendNib(input logic [3:0] v);
    dat = v;
    repeat (curDiv) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseStart(input logic en, input int n, input int d, input int lim);
    @(negedge clk);
    crcEn = en; blkTotal = 8'(n); divSel = 10'(d); toLimit = 16'(lim);
    curDiv = d; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // R1 R2 R3: start bit, nibble order, per-line CRC, closing nibble
  task automatic sendBlock(input int b, input logic badCrc, input logic badEnd);
    logic [15:0] c [4];
    logic [7:0]  by;
    logic [3:0]  nb;
    for (int j = 0; j < 4; j++) c[j] = '0;
    sendNib(4'hF);
    sendNib(4'hF);
    sendNib(4'h0);
    for (int i = 0; i < BYTES; i++) begin
      by = pat(b, i);
      for (int h = 0; h < 2; h++) begin
        nb = (h == 0) ? by[7:4] : by[3:0];
        for (int j = 0; j < 4; j++)
          c[j] = {c[j][14:0], 1'b0} ^ ((nb[j] ^ c[j][15]) ? 16'h1021 : 16'h0);
        sendNib(nb);
      end
    end
    for (int t = 15; t >= 0; t--) begin
      for (int j = 0; j < 4; j++) nb[j] = c[j][t];
      if (badCrc && t == 15) nb[2] = ~nb[2];
      sendNib(nb);
    end
    sendNib(badEnd ? 4'b0111 : 4'hF);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int nSend;
    int doneBase;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0 && blkCount == 8'd0, "R9 reset busy/count", int'(busy) + int'(blkCount), 0);
    check(errCode == 2'd0 && !errFlag, "R9 reset error", int'(errCode), 0);
    check(!outValid && !blkDone, "R9 reset strobes", int'(outValid) + int'(blkDone), 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0 && errCode == 2'd0, "R9 after release", int'(busy), 0);

    for (int v = 0; v < 6; v++) begin
      nSend = (VEC[v].badKind == 2'd2 || (VEC[v].badKind == 2'd1 && VEC[v].crcOn))
              ? int'(VEC[v].badBlk) + 1 : int'(VEC[v].nBlk);
      monBase = monTotal;
      monBad = 0;
      doneBase = doneTotal;
      pulseStart(VEC[v].crcOn, int'(VEC[v].nBlk), int'(VEC[v].dv), 50);
      for (int b = 0; b < nSend; b++)
        sendBlock(b, VEC[v].badKind == 2'd1 && b == int'(VEC[v].badBlk),
                     VEC[v].badKind == 2'd2 && b == int'(VEC[v].badBlk));
      sendNib(4'hF);
      sendNib(4'hF);
      check(busy == 1'b0, $sformatf("R7 vec%0d ends", v), int'(busy), 0);
      check(blkCount == 8'(VEC[v].expCnt), $sformatf("R4 R5 R7 vec%0d count", v),
            int'(blkCount), int'(VEC[v].expCnt));
      check(errCode == VEC[v].expErr, $sformatf("R4 R5 R6 vec%0d code", v),
            int'(errCode), int'(VEC[v].expErr));
      check(errFlag == (VEC[v].expErr != 2'd0), $sformatf("R9 vec%0d flag", v),
            int'(errFlag), int'(VEC[v].expErr != 2'd0));
      check(monTotal - monBase == nSend * BYTES, $sformatf("R2 vec%0d byte count", v),
            monTotal - monBase, nSend * BYTES);
      check(monBad == 0, $sformatf("R2 R1 vec%0d byte values", v), monBad, 0);
      check(doneTotal - doneBase == int'(VEC[v].expCnt), $sformatf("R7 vec%0d done pulses", v),
            doneTotal - doneBase, int'(VEC[v].expCnt));
    end

    // R8: timeout boundary, limit 20 samples at divide-by-2
    pulseStart(1'b1, 1, 2, 20);
    dat = 4'hF;
    repeat (38) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1 && errCode == 2'd0, "R8 before limit", int'(errCode), 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(errCode == 2'd3, "R8 timeout code", int'(errCode), 3);
    check(busy == 1'b0, "R8 timeout ends", int'(busy), 0);

    // R7: zero block count ignored, prior result untouched
    pulseStart(1'b1, 0, 2, 20);
    check(busy == 1'b0, "R7 zero total ignored", int'(busy), 0);
    check(errCode == 2'd3, "R9 zero total keeps code", int'(errCode), 3);

    // R1: divide value below 2 acts as 2, one good block
    monBase = monTotal;
    monBad = 0;
    pulseStart(1'b1, 1, 1, 50);
    curDiv = 2;
    sendBlock(0, 1'b0, 1'b0);
    sendNib(4'hF);
    check(blkCount == 8'd1 && errCode == 2'd0, "R1 clamped divider", int'(blkCount), 1);
    check(monBad == 0 && monTotal - monBase == BYTES, "R1 clamped bytes", monBad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule